// File: doc/BRIEF.md
# Checkerboard RAM Test Engine

This block is a self-test controller for an external byte-wide static RAM of 32K bytes. It checks one 8K-byte page per run. The page is picked by a two-bit select input that is sampled at start. A run has two phases. First the engine writes the alternating-bit value 55h to every byte of the page. Then it reads every byte back in ascending order and compares each one with that value. It stops at the first byte that differs.

The engine drives a plain synchronous SRAM master interface. Read data is taken one clock after the read enable, so each comparison is made in the cycle after its read. The page end is detected by comparing only the address bits above the page offset with the next page boundary. When a run ends, the engine drops busy and publishes a 14-bit status word. Bit 13 is the pass flag. The low 13 bits give the failing offset inside the page. The word stays unchanged until the next start. Four runs with selects 0 to 3 cover the whole RAM.

Top module: `cbist_top`

## Requirements
- R1: After reset, busy is 0, the status word is 0, and both the write and read enables are 0.
- R2: A start pulse while idle latches pageSel, and busy is 1 in the cycle after that start. The first access addresses page base pageSel*2000h.
- R3: In the write phase, every address of the page is written exactly once, in ascending order. Each write carries data 55h. The write and read enables are never high together.
- R4: No read is issued before all 8192 bytes of the page have been written.
- R5: In the read phase, page addresses are read in ascending order from the page base. Each read's data is compared with 55h in the following cycle.
- R6: On the first mismatch the run ends with status bit 13 = 0 and bits 12:0 = the failing offset. At most one read is issued beyond the failing byte.
- R7: When all bytes match, the run ends with status exactly 2000h: bit 13 = 1 and bits 12:0 = 0.
- R8: The last access of each phase is at page offset 1FFFh. No address outside the selected page is driven.
- R9: While halted, busy is low, no memory access is made, and the status word holds. A later start runs a fresh test.
- R10: A start pulse while busy has no effect. The run continues on the page latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run on the selected page |
| pageSel | input | 2 | 8K page to test, sampled at start |
| memAddr | output | 15 | RAM byte address |
| memWrData | output | 8 | RAM write data |
| memRdData | input | 8 | RAM read data, valid one cycle after memRe |
| memWe | output | 1 | RAM write enable |
| memRe | output | 1 | RAM read enable |
| busy | output | 1 | High from start until the run halts |
| statusWord | output | 14 | Bit 13 pass flag, bits 12:0 failing offset |

## Verification
The bench injects single-byte faults at three offsets: the first byte of a page, a middle byte, and the very last byte. An engine that compared in the wrong cycle would report a neighbouring offset. An engine that missed the final byte would report a pass on the last-byte fault. A memory model counts every write and read and follows the expected address. This catches a boundary compare that stops a page early or runs into the next page, and any read that slips in before the write phase has finished. One run gets a second start with another page select in the middle of the run; obeying it would move the addresses off the expected page. The bench also re-checks the status several cycles after each halt, so a status word that kept changing would be caught.

// File: rtl/cbist_pkg.sv
package cbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } engState_t;

  typedef struct packed {
    logic loadPage;
    logic rewind;
    logic advance;
    logic issueRead;
    logic markFail;
    logic markPass;
  } engStrobes_t;

endpackage

// File: rtl/cbist_datapath.sv
module cbist_datapath
  import cbist_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 13,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PATTERN = 8'h55
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  engStrobes_t                strobes,
  input  logic [ADDR_W-PAGE_W-1:0]   pageSel,
  input  logic [DATA_W-1:0]          memRdData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memWrData,
  output logic [PAGE_W:0]            statusWord,
  output logic                       lastAddr,
  output logic                       mismatchHit
);
  localparam int SEL_W = ADDR_W - PAGE_W;

  logic [ADDR_W:0]   addrCnt;
  logic [ADDR_W:0]   nextAddr;
  logic [SEL_W-1:0]  pageReg;
  logic [SEL_W-1:0]  basePage;
  logic [SEL_W:0]    boundaryHi;
  logic              pendValid;
  logic [PAGE_W-1:0] pendOff;

  // Only the bits above the page offset take part in the end-of-page test.
  always_comb begin
    nextAddr   = addrCnt + {{ADDR_W{1'b0}}, 1'b1};
    boundaryHi = {1'b0, pageReg} + {{SEL_W{1'b0}}, 1'b1};
    lastAddr   = (nextAddr[ADDR_W:PAGE_W] == boundaryHi);
    basePage   = strobes.loadPage ? pageSel : pageReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg <= '0;
      addrCnt <= '0;
    end else begin
      if (strobes.loadPage) pageReg <= pageSel;
      if (strobes.rewind)
        addrCnt <= {1'b0, basePage, {PAGE_W{1'b0}}};
      else if (strobes.advance)
        addrCnt <= nextAddr;
    end
  end

  // One-slot read pipeline: the offset waits here until its data arrives.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendOff   <= '0;
    end else begin
      pendValid <= strobes.issueRead;
      if (strobes.issueRead) pendOff <= addrCnt[PAGE_W-1:0];
    end
  end

  assign mismatchHit = pendValid && (memRdData != PATTERN);

  always_ff @(posedge clk) begin
    if (!rstN)
      statusWord <= '0;
    else if (strobes.markFail)
      statusWord <= {1'b0, pendOff};
    else if (strobes.markPass)
      statusWord <= {1'b1, {PAGE_W{1'b0}}};
  end

  assign memAddr   = addrCnt[ADDR_W-1:0];
  assign memWrData = PATTERN;

endmodule

// File: rtl/cbist_control.sv
module cbist_control
  import cbist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        lastAddr,
  input  logic        mismatchHit,
  output engStrobes_t strobes,
  output logic        memWe,
  output logic        memRe,
  output logic        busy
);
  engState_t state, nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.loadPage = 1'b1;
          strobes.rewind   = 1'b1;
          nextState        = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (lastAddr) begin
          strobes.rewind = 1'b1;
          nextState      = ST_READ;
        end else begin
          strobes.advance = 1'b1;
        end
      end
      ST_READ: begin
        strobes.issueRead = 1'b1;
        if (mismatchHit) begin
          strobes.markFail = 1'b1;
          nextState        = ST_IDLE;
        end else if (lastAddr) begin
          nextState = ST_DRAIN;
        end else begin
          strobes.advance = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (mismatchHit) strobes.markFail = 1'b1;
        else             strobes.markPass = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign memWe = (state == ST_WRITE);
  assign memRe = (state == ST_READ);
  assign busy  = (state != ST_IDLE);

endmodule

// File: rtl/cbist_top.sv
module cbist_top
  import cbist_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 13,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PATTERN = 8'h55
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] pageSel,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWrData,
  input  logic [DATA_W-1:0]        memRdData,
  output logic                     memWe,
  output logic                     memRe,
  output logic                     busy,
  output logic [PAGE_W:0]          statusWord
);
  engStrobes_t strobes;
  logic        lastAddr;
  logic        mismatchHit;

  cbist_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .lastAddr    (lastAddr),
    .mismatchHit (mismatchHit),
    .strobes     (strobes),
    .memWe       (memWe),
    .memRe       (memRe),
    .busy        (busy)
  );

  cbist_datapath #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .DATA_W  (DATA_W),
    .PATTERN (PATTERN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pageSel     (pageSel),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .statusWord  (statusWord),
    .lastAddr    (lastAddr),
    .mismatchHit (mismatchHit)
  );

endmodule

// File: rtl/cbist_checker.sv
module cbist_checker #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 13,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PATTERN = 8'h55
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              memWe,
  input logic              memRe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic [PAGE_W:0]   statusWord
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R2
  AST_FIRST_WRITE_BASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> (memAddr[PAGE_W-1:0] == '0)); // R2
  AST_NO_WE_RE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R3
  AST_WRITE_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWrData == PATTERN)); // R3
  AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) + 1'b1)); // R3
  AST_READ_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && $past(memRe)) |-> (memAddr == $past(memAddr) + 1'b1)); // R5
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[PAGE_W] |-> (statusWord[PAGE_W-1:0] == '0)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe)); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(statusWord)); // R9
endmodule

bind cbist_top cbist_checker #(
  .ADDR_W  (ADDR_W),
  .PAGE_W  (PAGE_W),
  .DATA_W  (DATA_W),
  .PATTERN (PATTERN)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .memWe      (memWe),
  .memRe      (memRe),
  .memAddr    (memAddr),
  .memWrData  (memWrData),
  .statusWord (statusWord)
);

// File: tb/cbist_top_test.sv
module cbist_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_BYTES = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  pageSel = 2'd0;
  logic [14:0] memAddr;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData = 8'h00;
  logic        memWe, memRe, busy;
  logic [13:0] statusWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // memory model bookkeeping
  int expWr = 0, expRd = 0, wrCount = 0, rdCount = 0, protoErr = 0;
  bit faultEn = 0;
  int faultAddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbist_top uut (
    .clk(clk), .rstN(rstN), .start(start), .pageSel(pageSel),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .memWe(memWe), .memRe(memRe), .busy(busy), .statusWord(statusWord)
  );

  // Bus model: checks order, data and page; returns 55h except at the fault byte.
  always @(posedge clk) begin
    if (memWe) begin
      if (memWrData !== 8'h55 || int'(memAddr) != expWr) protoErr <= protoErr + 1;
      expWr   <= expWr + 1;
      wrCount <= wrCount + 1;
    end
    if (memRe) begin
      if (wrCount != PAGE_BYTES || int'(memAddr) != expRd) protoErr <= protoErr + 1;
      expRd   <= expRd + 1;
      rdCount <= rdCount + 1;
      memRdData <= (faultEn && int'(memAddr) == faultAddr) ? 8'h54 : 8'h55;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One directed scenario: run a page, optionally inject a fault, optionally poke start.
  task automatic runPage(input int page, input bit inject, input int off, input bit poke);
    int expStatus, expReads, holdStatus, holdReads;
    @(negedge clk);
    expWr = page * PAGE_BYTES; expRd = page * PAGE_BYTES;
    wrCount = 0; rdCount = 0; protoErr = 0;
    faultEn = inject; faultAddr = page * PAGE_BYTES + off;
    pageSel = 2'(page); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (50) @(negedge clk);
      pageSel = 2'(page ^ 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy kept after ignored start", int'(busy), 1);
    end
    while (busy) @(negedge clk);
    expStatus = inject ? off : 14'h2000;
    expReads  = (!inject || off == PAGE_BYTES - 1) ? PAGE_BYTES : off + 2;
    chk(wrCount == PAGE_BYTES, "R3 R8 write count", wrCount, PAGE_BYTES);
    chk(protoErr == 0, "R3 R4 R5 R8 R10 access order/data/page", protoErr, 0);
    chk(int'(statusWord) == expStatus, inject ? "R6 fail status" : "R7 pass status",
        int'(statusWord), expStatus);
    chk(rdCount == expReads, inject ? "R6 reads issued" : "R5 reads issued", rdCount, expReads);
    holdStatus = int'(statusWord); holdReads = rdCount;
    repeat (6) @(negedge clk);
    chk(int'(statusWord) == holdStatus && rdCount == holdReads && !memWe && !memRe && !busy,
        "R9 halted hold", int'(statusWord), holdStatus);
  endtask

  task automatic checkReset();
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(statusWord == 14'h0, "R1 status reset", int'(statusWord), 0);
    chk(!memWe && !memRe, "R1 enables reset", int'({memWe, memRe}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();
    runPage(0, 1'b0, 0, 1'b0);        // R7 clean page 0
    runPage(1, 1'b1, 13'h0123, 1'b0); // R6 mid-page fault
    runPage(2, 1'b1, 13'h1FFF, 1'b0); // R6 R8 last-byte fault
    runPage(3, 1'b1, 13'h0000, 1'b1); // R6 first byte, R10 ignored start
    runPage(3, 1'b0, 0, 1'b0);        // R9 restart after fail, R7
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule